// File: doc/BRIEF.md
# Condition-code relative branch unit

This unit resolves one short relative branch per request. The caller presents the fetched opcode, a signed 8-bit offset byte, the 16-bit address of the opcode, and three condition-code flags: the interrupt mask, negative and zero. It then pulses `start`. One clock later the unit reports whether the branch is taken, the address of the next instruction, and how many instruction cycles the branch costs. A `done` pulse marks the cycle in which these results first appear.

Seven opcodes are recognised. One always branches, one never branches, three test the zero or negative flag, and two test the interrupt mask. All of them are two bytes long and cost the same number of cycles. Any other opcode is flagged as not belonging to this unit. In that case the address passes through unchanged and the cycle count is zero. The unit never writes a flag.

Top module: `cc_branch_unit`

## Requirements
- R1: A taken branch yields next_pc = pc_in + 2 + sign-extended disp, where disp is two's complement (-128..+127) and the sum wraps modulo 2^16.
- R2: A recognised branch that is not taken yields next_pc = pc_in + 2, wrapping modulo 2^16, with taken = 0.
- R3: Opcode 0x20 is always taken. Opcode 0x21 is never taken. Neither depends on any flag.
- R4: Opcode 0x26 is taken when zero_flag = 0. Opcode 0x2A is taken when neg_flag = 0. Opcode 0x2B is taken when neg_flag = 1.
- R5: Opcode 0x2C is taken when imask_flag = 0. Opcode 0x2D is taken when imask_flag = 1.
- R6: Every recognised opcode reports cycles = 3, whether or not it is taken.
- R7: Any other opcode gives unsupported = 1, next_pc = pc_in, taken = 0 and cycles = 0. A recognised opcode gives unsupported = 0.
- R8: Results are registered. They appear in the cycle after a cycle with start = 1, and done is high in exactly those cycles. Without start, every result output holds its value, whatever the inputs do.
- R9: While reset is asserted, and after it is released, next_pc, taken, cycles, unsupported and done are all 0 until the first start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the unit. |
| start | input | 1 | One-cycle request to resolve the presented instruction |
| opcode | input | 8 | Fetched opcode byte |
| disp | input | 8 | Signed relative offset byte |
| pc_in | input | 16 | Address of the opcode byte |
| imask_flag | input | 1 | Interrupt-mask flag |
| neg_flag | input | 1 | Negative flag |
| zero_flag | input | 1 | Zero flag |
| next_pc | output | 16 | Address of the next instruction |
| taken | output | 1 | Branch taken |
| cycles | output | 4 | Instruction cycle count |
| unsupported | output | 1 | Opcode is not handled by this unit |
| done | output | 1 | High in the cycle after each start |

## Verification
A new `start` can arrive in the same cycle in which `done` reports the previous request. In that cycle the result registers must load the new request without dropping or mixing with the one just reported. The bench provokes this by walking its whole vector table with `start` held high on every cycle. Each result is compared in the cycle after its own request, with `done` expected high throughout, and afterwards the outputs must hold once `start` falls. Address wrap in both directions and taken/not-taken pairs for each flag are part of the same stream.

// File: rtl/cc_branch_pkg.sv
package cc_branch_pkg;

  typedef enum logic [2:0] {
    COND_ALWAYS = 3'd0,
    COND_NEVER  = 3'd1,
    COND_Z_CLR  = 3'd2,
    COND_N_CLR  = 3'd3,
    COND_N_SET  = 3'd4,
    COND_I_CLR  = 3'd5,
    COND_I_SET  = 3'd6
  } cond_sel_e;

  localparam logic [7:0] OP_ALWAYS = 8'h20;
  localparam logic [7:0] OP_NEVER  = 8'h21;
  localparam logic [7:0] OP_Z_CLR  = 8'h26;
  localparam logic [7:0] OP_N_CLR  = 8'h2A;
  localparam logic [7:0] OP_N_SET  = 8'h2B;
  localparam logic [7:0] OP_I_CLR  = 8'h2C;
  localparam logic [7:0] OP_I_SET  = 8'h2D;

endpackage

// File: rtl/cc_branch_rst_sync.sv
module cc_branch_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cc_branch_decode.sv
module cc_branch_decode
  import cc_branch_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] opcode,
  output logic            known,
  output cond_sel_e       cond
);
  always_comb begin
    known = 1'b1;
    cond  = COND_NEVER;
    unique case (opcode)
      OP_ALWAYS: cond = COND_ALWAYS;
      OP_NEVER:  cond = COND_NEVER;
      OP_Z_CLR:  cond = COND_Z_CLR;
      OP_N_CLR:  cond = COND_N_CLR;
      OP_N_SET:  cond = COND_N_SET;
      OP_I_CLR:  cond = COND_I_CLR;
      OP_I_SET:  cond = COND_I_SET;
      default:   known = 1'b0;
    endcase
  end
endmodule

// File: rtl/cc_branch_cond_eval.sv
module cc_branch_cond_eval
  import cc_branch_pkg::*;
(
  input  cond_sel_e cond,
  input  logic      imask_flag,
  input  logic      neg_flag,
  input  logic      zero_flag,
  output logic      hit
);
  always_comb begin
    case (cond)
      COND_ALWAYS: hit = 1'b1;
      COND_Z_CLR:  hit = ~zero_flag;
      COND_N_CLR:  hit = ~neg_flag;
      COND_N_SET:  hit = neg_flag;
      COND_I_CLR:  hit = ~imask_flag;
      COND_I_SET:  hit = imask_flag;
      default:     hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cc_branch_target.sv
module cc_branch_target #(
  parameter int PC_W      = 16,
  parameter int DISP_W    = 8,
  parameter int INSTR_LEN = 2
) (
  input  logic [PC_W-1:0]   pc_in,
  input  logic [DISP_W-1:0] disp,
  output logic [PC_W-1:0]   fall_pc,
  output logic [PC_W-1:0]   jump_pc
);
  localparam int            EXT_W = PC_W - DISP_W;
  localparam logic [PC_W-1:0] LEN_V = PC_W'(INSTR_LEN);

  logic [PC_W-1:0] disp_ext;

  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign fall_pc  = pc_in + LEN_V;
  assign jump_pc  = fall_pc + disp_ext;
endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
  import cc_branch_pkg::*;
#(
  parameter int PC_W          = 16,
  parameter int DISP_W        = 8,
  parameter int OP_W          = 8,
  parameter int CYC_W         = 4,
  parameter int INSTR_LEN     = 2,
  parameter int BRANCH_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DISP_W-1:0] disp,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              imask_flag,
  input  logic              neg_flag,
  input  logic              zero_flag,
  output logic [PC_W-1:0]   next_pc,
  output logic              taken,
  output logic [CYC_W-1:0]  cycles,
  output logic              unsupported,
  output logic              done
);
  localparam logic [CYC_W-1:0] CYC_V = CYC_W'(BRANCH_CYCLES);
  localparam logic [PC_W-1:0]  LEN_V = PC_W'(INSTR_LEN);

  logic            rst_n_sync;
  logic            known;
  cond_sel_e       cond;
  logic            hit;
  logic [PC_W-1:0] fall_pc, jump_pc;

  logic [PC_W-1:0]  pc_d;
  logic             taken_d, unsup_d;
  logic [CYC_W-1:0] cyc_d;

  cc_branch_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  cc_branch_decode #(.OP_W(OP_W)) u_dec (
    .opcode(opcode), .known(known), .cond(cond)
  );

  cc_branch_cond_eval u_eval (
    .cond(cond), .imask_flag(imask_flag), .neg_flag(neg_flag),
    .zero_flag(zero_flag), .hit(hit)
  );

  cc_branch_target #(.PC_W(PC_W), .DISP_W(DISP_W), .INSTR_LEN(INSTR_LEN)) u_tgt (
    .pc_in(pc_in), .disp(disp), .fall_pc(fall_pc), .jump_pc(jump_pc)
  );

  // next-state
  always_comb begin
    if (known) begin
      taken_d = hit;
      pc_d    = hit ? jump_pc : fall_pc;
      cyc_d   = CYC_V;
      unsup_d = 1'b0;
    end else begin
      taken_d = 1'b0;
      pc_d    = pc_in;
      cyc_d   = '0;
      unsup_d = 1'b1;
    end
  end

  // result registers, loaded only on start
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      next_pc     <= '0;
      taken       <= 1'b0;
      cycles      <= '0;
      unsupported <= 1'b0;
    end else if (start) begin
      next_pc     <= pc_d;
      taken       <= taken_d;
      cycles      <= cyc_d;
      unsupported <= unsup_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) done <= 1'b0;
    else             done <= start;
  end

  AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n_sync)
    start |=> done);                                                     // R8
  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !start |=> !done && $stable(next_pc) && $stable(taken));             // R8
  AST_UNSUP_PASS_PC: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (start && !known) |=> unsupported && !taken && cycles == '0
      && next_pc == $past(pc_in));                                       // R7
  AST_FIXED_CYCLES: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (start && known) |=> cycles == CYC_V && !unsupported);              // R6
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (start && known) |=> taken || next_pc == $past(pc_in) + LEN_V);     // R2
  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (start && opcode == OP_ALWAYS) |=> taken);                          // R3
  AST_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (start && opcode == OP_NEVER) |=> !taken);                          // R3
endmodule

// File: tb/cc_branch_unit_test.sv
module cc_branch_unit_test;
  // entry: {opcode, disp, pc, {i,n,z}, exp_pc, exp_taken, exp_cycles, exp_unsup}
  localparam int N_VEC = 18;
  localparam logic [56:0] VECS [N_VEC] = '{
    {8'h20, 8'h10, 16'h1000, 3'b000, 16'h1012, 1'b1, 4'd3, 1'b0},
    {8'h21, 8'h10, 16'h1000, 3'b111, 16'h1002, 1'b0, 4'd3, 1'b0},
    {8'h26, 8'hF0, 16'h2000, 3'b000, 16'h1FF2, 1'b1, 4'd3, 1'b0},
    {8'h26, 8'hF0, 16'h2000, 3'b001, 16'h2002, 1'b0, 4'd3, 1'b0},
    {8'h2A, 8'h05, 16'h3000, 3'b000, 16'h3007, 1'b1, 4'd3, 1'b0},
    {8'h2A, 8'h05, 16'h3000, 3'b010, 16'h3002, 1'b0, 4'd3, 1'b0},
    {8'h2B, 8'h80, 16'h4000, 3'b010, 16'h3F82, 1'b1, 4'd3, 1'b0},
    {8'h2B, 8'h80, 16'h4000, 3'b000, 16'h4002, 1'b0, 4'd3, 1'b0},
    {8'h2C, 8'h7F, 16'h5000, 3'b000, 16'h5081, 1'b1, 4'd3, 1'b0},
    {8'h2C, 8'h7F, 16'h5000, 3'b100, 16'h5002, 1'b0, 4'd3, 1'b0},
    {8'h2D, 8'h01, 16'h6000, 3'b100, 16'h6003, 1'b1, 4'd3, 1'b0},
    {8'h2D, 8'h01, 16'h6000, 3'b011, 16'h6002, 1'b0, 4'd3, 1'b0},
    {8'h20, 8'h7F, 16'hFFF0, 3'b111, 16'h0071, 1'b1, 4'd3, 1'b0},
    {8'h20, 8'h80, 16'h0010, 3'b000, 16'hFF92, 1'b1, 4'd3, 1'b0},
    {8'h21, 8'h00, 16'hFFFF, 3'b000, 16'h0001, 1'b0, 4'd3, 1'b0},
    {8'h27, 8'h10, 16'h1234, 3'b000, 16'h1234, 1'b0, 4'd0, 1'b1},
    {8'h00, 8'h00, 16'hABCD, 3'b111, 16'hABCD, 1'b0, 4'd0, 1'b1},
    {8'h20, 8'hFE, 16'h0100, 3'b000, 16'h0100, 1'b1, 4'd3, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  disp = 8'h00;
  logic [15:0] pc_in = 16'h0000;
  logic        imask_flag = 1'b0, neg_flag = 1'b0, zero_flag = 1'b0;
  logic [15:0] next_pc;
  logic        taken, unsupported, done;
  logic [3:0]  cycles;

  int n_chk = 0;
  int n_bad = 0;
  int n_clk = 0;

  always #5 clk = ~clk;

  cc_branch_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .disp(disp),
    .pc_in(pc_in), .imask_flag(imask_flag), .neg_flag(neg_flag),
    .zero_flag(zero_flag), .next_pc(next_pc), .taken(taken), .cycles(cycles),
    .unsupported(unsupported), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_result(input string req, input logic [56:0] v);
    check({req, " next_pc"},     32'(next_pc),     32'(v[21:6]));
    check({req, " taken"},       32'(taken),       32'(v[5]));
    check({req, " cycles"},      32'(cycles),      32'(v[4:1]));
    check({req, " unsupported"}, 32'(unsupported), 32'(v[0]));
    check({req, " done"},        32'(done),        32'd1);
  endtask

  always @(posedge clk) begin
    n_clk++;
    if (n_clk > 5000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <5000 cycles", n_clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R9: reset state, during and after reset
    repeat (3) @(negedge clk);
    check("R9 next_pc in reset", 32'(next_pc), 32'd0);
    check("R9 done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 next_pc after reset", 32'(next_pc), 32'd0);
    check("R9 taken after reset", 32'(taken), 32'd0);
    check("R9 cycles after reset", 32'(cycles), 32'd0);
    check("R9 unsupported after reset", 32'(unsupported), 32'd0);
    check("R9 done after reset", 32'(done), 32'd0);

    // Table walk, start held every cycle (R1 R2 R3 R4 R5 R6 R7 R8)
    for (int i = 0; i < N_VEC; i++) begin
      if (i > 0) check_result("R1/R2/R3/R4/R5/R6/R7/R8 vector", VECS[i-1]);
      start      = 1'b1;
      opcode     = VECS[i][56:49];
      disp       = VECS[i][48:41];
      pc_in      = VECS[i][40:25];
      imask_flag = VECS[i][24];
      neg_flag   = VECS[i][23];
      zero_flag  = VECS[i][22];
      @(negedge clk);
    end
    check_result("R8 last vector", VECS[N_VEC-1]);

    // R8: no start -> done low, outputs hold despite changing inputs
    start = 1'b0;
    opcode = 8'h21; pc_in = 16'h7777; disp = 8'h33;
    @(negedge clk);
    check("R8 done drops", 32'(done), 32'd0);
    check("R8 next_pc holds", 32'(next_pc), 32'h0100);
    check("R8 taken holds", 32'(taken), 32'd1);
    @(negedge clk);
    check("R8 cycles holds", 32'(cycles), 32'd3);

    // R7 then R6 with isolated strobes
    start = 1'b1; opcode = 8'h2E; pc_in = 16'h4321;
    @(negedge clk);
    start = 1'b0;
    check("R7 unsupported", 32'(unsupported), 32'd1);
    check("R7 pc passthrough", 32'(next_pc), 32'h4321);
    check("R7 cycles zero", 32'(cycles), 32'd0);
    @(negedge clk);
    check("R8 single done", 32'(done), 32'd0);
    start = 1'b1; opcode = 8'h26; zero_flag = 1'b1; pc_in = 16'hFFFE; disp = 8'h10;
    @(negedge clk);
    start = 1'b0;
    check("R2 not-taken wrap", 32'(next_pc), 32'h0000);
    check("R6 not-taken cycles", 32'(cycles), 32'd3);
    check("R7 clears unsupported", 32'(unsupported), 32'd0);

    // R9: reset mid-stream clears results
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 re-reset next_pc", 32'(next_pc), 32'd0);
    check("R9 re-reset cycles", 32'(cycles), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule